// File: doc/BRIEF.md
# Sample-and-Hold Phase Timing Controller

This block drives the analog switch of one converter channel in sample-and-hold operation. It walks the channel through a repeating four-step cycle: sample, hold, refresh and a second hold. Each step lasts a programmed number of periods of a slow low-speed clock. The hold and refresh durations arrive as static configuration inputs. Software must keep them stable while the sequence runs.

The sample duration is written from the bus clock domain and then copied into the slow domain through a toggle handshake. The handshake has a synchroniser of `SYNC_N` flops in each direction. A busy flag is raised for every transfer, and also when sample-and-hold mode is switched on. While the flag is up and the channel is enabled, further sample-time writes are dropped. While the channel is disabled, writes are always taken. If a transfer is already in flight, the newest value is parked and sent once the current transfer completes. The flag stays up until that second transfer has also completed.

The slow-domain state machine has five states: `ST_IDLE`, `ST_SAMPLE`, `ST_HOLD_A`, `ST_REFRESH` and `ST_HOLD_B`. It has these transitions:
- `ST_IDLE` to the first active phase, searched from `ST_SAMPLE`, when the synchronised run condition (mode on and channel on) is true.
- Each active phase to the next active phase in the cyclic order `ST_SAMPLE` → `ST_HOLD_A` → `ST_REFRESH` → `ST_HOLD_B` → `ST_SAMPLE`, when its down-counter reaches zero.
- Any active phase to `ST_IDLE` when the run condition drops.

A phase whose duration is zero is skipped. If all durations are zero, the machine remains in `ST_IDLE`.

Top module: `snh_timing_ctrl`

## Requirements
- R1: After reset, `busy`, `st_value`, `sample_o`, `hold_o` and `refresh_o` are all zero.
- R2: A sample-time write that is accepted sets `st_value` to the written data one bus clock later, and `busy` reads 1 in that same cycle.
- R3: After a single transfer is launched with no transfer in flight, `busy` falls between 2 and 4 slow-clock periods later, allowing a few extra bus cycles for the return synchroniser.
- R4: While `busy` is 1 and `chan_en` is 1, a write leaves `st_value` unchanged.
- R5: While `chan_en` is 0, a write is accepted even when `busy` is 1. The most recently written value is the one the slow domain finally uses as the sample duration.
- R6: A rising edge on `mode_en` makes `busy` read 1 one bus clock later.
- R7: While `mode_en` and `chan_en` are both 1, at most one of `sample_o`, `hold_o` and `refresh_o` is 1. The active phases follow the cyclic order sample, hold, refresh, hold.
- R8: The sample phase lasts `st_value` slow periods. Each hold phase lasts `hold_time` slow periods. The refresh phase lasts `refresh_time` slow periods.
- R9: A phase with a zero duration is skipped. Two adjacent phases of the same kind therefore merge into one run. With all durations zero, every phase output stays 0.
- R10: Within 5 slow periods after `mode_en` or `chan_en` falls, all three phase outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ls_clk | input | 1 | Slow low-speed clock that times the phases |
| chan_en | input | 1 | Channel enabled (bus domain) |
| mode_en | input | 1 | Sample-and-hold mode selected (bus domain) |
| st_wr | input | 1 | Sample-time write strobe |
| st_wdata | input | ST_W | Sample-time write data |
| hold_time | input | HT_W | Hold duration in slow periods (static) |
| refresh_time | input | RT_W | Refresh duration in slow periods (static) |
| st_value | output | ST_W | Current bus-side sample-time value |
| busy | output | 1 | Sample-time transfer in progress |
| sample_o | output | 1 | Sample phase active |
| hold_o | output | 1 | Hold phase active |
| refresh_o | output | 1 | Refresh phase active |

## Verification
The hardest state to reach from the ports is a write that is accepted while a transfer is already in flight. This requires a disabled channel, a busy flag that is still up, and a second write landing inside a window only a few slow periods long. The bench issues back-to-back writes on consecutive bus cycles with the channel off. It then starts the sequencer and measures the length of the sample phase, which shows whether the parked value, rather than the first value, reached the slow domain. Random duration triples, many of which contain zeros, drive the skip and merge paths. Each triple is compared against a run-length list that the bench computes itself.

// File: rtl/snh_pkg.sv
package snh_pkg;

    // bit 2 marks an active phase, bits 1:0 give the position in the cycle
    typedef enum logic [2:0] {
        ST_IDLE    = 3'b000,
        ST_SAMPLE  = 3'b100,
        ST_HOLD_A  = 3'b101,
        ST_REFRESH = 3'b110,
        ST_HOLD_B  = 3'b111
    } snh_state_e;

    localparam int unsigned PHASE_CNT = 4;

endpackage

// File: rtl/snh_bus_side.sv
module snh_bus_side #(
    parameter int ST_W   = 10,
    parameter int SYNC_N = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            chan_en,
    input  logic            mode_en,
    input  logic            wr,
    input  logic [ST_W-1:0] wdata,
    input  logic            ack_tgl,
    output logic [ST_W-1:0] st_value,
    output logic            busy,
    output logic            req_tgl,
    output logic [ST_W-1:0] tx_data,
    output logic            run_q
);

    logic [SYNC_N-1:0] ack_sync;
    logic              mode_d;
    logic              pending;
    logic              in_flight;
    logic              accept;
    logic              want;
    logic              launch;

    assign in_flight = req_tgl ^ ack_sync[SYNC_N-1];
    assign busy      = in_flight | pending;
    assign accept    = wr & (~busy | ~chan_en);
    assign want      = accept | (mode_en & ~mode_d) | pending;
    assign launch    = want & ~in_flight;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_sync <= '0;
            mode_d   <= 1'b0;
            run_q    <= 1'b0;
            pending  <= 1'b0;
            req_tgl  <= 1'b0;
            st_value <= '0;
            tx_data  <= '0;
        end else begin
            ack_sync <= {ack_sync[SYNC_N-2:0], ack_tgl};
            mode_d   <= mode_en;
            run_q    <= mode_en & chan_en;
            if (accept) begin
                st_value <= wdata;
            end
            if (launch) begin
                req_tgl <= ~req_tgl;
                tx_data <= accept ? wdata : st_value;
                pending <= 1'b0;
            end else if (want) begin
                pending <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/snh_slow_side.sv
module snh_slow_side #(
    parameter int ST_W   = 10,
    parameter int SYNC_N = 2
) (
    input  logic            ls_clk,
    input  logic            rst_n,
    input  logic            req_tgl,
    input  logic [ST_W-1:0] tx_data,
    input  logic            run_async,
    output logic            ack_tgl,
    output logic [ST_W-1:0] st_slow,
    output logic            run_s
);

    logic [SYNC_N:0]   req_sync;
    logic [SYNC_N-1:0] run_sync;
    logic              req_edge;

    assign req_edge = req_sync[SYNC_N-1] ^ req_sync[SYNC_N];
    assign ack_tgl  = req_sync[SYNC_N];
    assign run_s    = run_sync[SYNC_N-1];

    always_ff @(posedge ls_clk or negedge rst_n) begin
        if (!rst_n) begin
            req_sync <= '0;
            run_sync <= '0;
            st_slow  <= '0;
        end else begin
            req_sync <= {req_sync[SYNC_N-1:0], req_tgl};
            run_sync <= {run_sync[SYNC_N-2:0], run_async};
            if (req_edge) begin
                st_slow <= tx_data;
            end
        end
    end

endmodule

// File: rtl/snh_phase_fsm.sv
module snh_phase_fsm
    import snh_pkg::*;
#(
    parameter int ST_W = 10,
    parameter int HT_W = 10,
    parameter int RT_W = 8
) (
    input  logic            ls_clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [ST_W-1:0] st_dur,
    input  logic [HT_W-1:0] ht_dur,
    input  logic [RT_W-1:0] rt_dur,
    output logic            sample_o,
    output logic            hold_o,
    output logic            refresh_o
);

    localparam int SH_W  = (ST_W > HT_W) ? ST_W : HT_W;
    localparam int CNT_W = (SH_W > RT_W) ? SH_W : RT_W;

    snh_state_e             state;
    snh_state_e             nxt;
    logic                   adv;
    logic [CNT_W-1:0]       cnt;
    logic [CNT_W-1:0]       dur [PHASE_CNT];
    logic [PHASE_CNT-1:0]   live;
    logic [CNT_W-1:0]       nxt_dur;

    always_comb begin
        dur[0] = CNT_W'(st_dur);
        dur[1] = CNT_W'(ht_dur);
        dur[2] = CNT_W'(rt_dur);
        dur[3] = CNT_W'(ht_dur);
    end

    for (genvar g = 0; g < PHASE_CNT; g++) begin : g_live
        assign live[g] = (dur[g] != '0);
    end

    // first phase after 'from' (cyclic, itself last) whose duration is non-zero
    function automatic logic [2:0] pick_next(input logic [1:0] from,
                                             input logic [PHASE_CNT-1:0] act);
        logic [2:0] found;
        logic [1:0] cand;
        found = 3'b000;
        for (int k = PHASE_CNT; k >= 1; k--) begin
            cand = from + 2'(k);
            if (act[cand]) found = {1'b1, cand};
        end
        return found;
    endfunction

    always_comb begin
        nxt = state;
        adv = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (run) begin
                    adv = 1'b1;
                    nxt = snh_state_e'(pick_next(2'd3, live));
                end
            end
            ST_SAMPLE, ST_HOLD_A, ST_REFRESH, ST_HOLD_B: begin
                if (!run) begin
                    nxt = ST_IDLE;
                end else if (cnt == '0) begin
                    adv = 1'b1;
                    nxt = snh_state_e'(pick_next(state[1:0], live));
                end
            end
        endcase
    end

    assign nxt_dur = dur[nxt[1:0]];

    always_ff @(posedge ls_clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (adv) begin
                cnt <= nxt[2] ? (nxt_dur - 1'b1) : '0;
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    always_comb begin
        sample_o  = 1'b0;
        hold_o    = 1'b0;
        refresh_o = 1'b0;
        unique case (state)
            ST_IDLE:               ;
            ST_SAMPLE:             sample_o  = 1'b1;
            ST_HOLD_A, ST_HOLD_B:  hold_o    = 1'b1;
            ST_REFRESH:            refresh_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/snh_timing_ctrl.sv
module snh_timing_ctrl #(
    parameter int ST_W   = 10,
    parameter int HT_W   = 10,
    parameter int RT_W   = 8,
    parameter int SYNC_N = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ls_clk,
    input  logic            chan_en,
    input  logic            mode_en,
    input  logic            st_wr,
    input  logic [ST_W-1:0] st_wdata,
    input  logic [HT_W-1:0] hold_time,
    input  logic [RT_W-1:0] refresh_time,
    output logic [ST_W-1:0] st_value,
    output logic            busy,
    output logic            sample_o,
    output logic            hold_o,
    output logic            refresh_o
);

    logic            req_tgl;
    logic            ack_tgl;
    logic            run_q;
    logic            run_s;
    logic [ST_W-1:0] tx_data;
    logic [ST_W-1:0] st_slow;

    snh_bus_side #(.ST_W(ST_W), .SYNC_N(SYNC_N)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_en  (chan_en),
        .mode_en  (mode_en),
        .wr       (st_wr),
        .wdata    (st_wdata),
        .ack_tgl  (ack_tgl),
        .st_value (st_value),
        .busy     (busy),
        .req_tgl  (req_tgl),
        .tx_data  (tx_data),
        .run_q    (run_q)
    );

    snh_slow_side #(.ST_W(ST_W), .SYNC_N(SYNC_N)) u_slow (
        .ls_clk    (ls_clk),
        .rst_n     (rst_n),
        .req_tgl   (req_tgl),
        .tx_data   (tx_data),
        .run_async (run_q),
        .ack_tgl   (ack_tgl),
        .st_slow   (st_slow),
        .run_s     (run_s)
    );

    snh_phase_fsm #(.ST_W(ST_W), .HT_W(HT_W), .RT_W(RT_W)) u_fsm (
        .ls_clk    (ls_clk),
        .rst_n     (rst_n),
        .run       (run_s),
        .st_dur    (st_slow),
        .ht_dur    (hold_time),
        .rt_dur    (refresh_time),
        .sample_o  (sample_o),
        .hold_o    (hold_o),
        .refresh_o (refresh_o)
    );

endmodule

// File: rtl/snh_timing_chk.sv
module snh_timing_chk #(
    parameter int ST_W = 10,
    parameter int HT_W = 10,
    parameter int RT_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ls_clk,
    input logic            chan_en,
    input logic            mode_en,
    input logic            st_wr,
    input logic [ST_W-1:0] st_wdata,
    input logic [HT_W-1:0] hold_time,
    input logic [RT_W-1:0] refresh_time,
    input logic [ST_W-1:0] st_value,
    input logic            busy,
    input logic            sample_o,
    input logic            hold_o,
    input logic            refresh_o
);

    assert_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && (!busy || !chan_en)) |=> (st_value == $past(st_wdata) && busy));

    assert_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && busy && chan_en) |=> $stable(st_value));

    assert_mode_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_en) |=> busy);

    assert_onehot_R7: assert property (@(posedge ls_clk) disable iff (!rst_n)
        $onehot0({sample_o, hold_o, refresh_o}));

    assert_after_sample_R7: assert property (@(posedge ls_clk) disable iff (!rst_n)
        ($fell(sample_o) && hold_time != '0) |-> !refresh_o);

    assert_before_refresh_R7: assert property (@(posedge ls_clk) disable iff (!rst_n)
        ($rose(refresh_o) && hold_time != '0) |-> $past(hold_o));

    assert_quiet_R9: assert property (@(posedge ls_clk) disable iff (!rst_n)
        (hold_time == '0 && refresh_time == '0) |-> (!hold_o && !refresh_o));

endmodule

bind snh_timing_ctrl snh_timing_chk #(.ST_W(ST_W), .HT_W(HT_W), .RT_W(RT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ls_clk       (ls_clk),
    .chan_en      (chan_en),
    .mode_en      (mode_en),
    .st_wr        (st_wr),
    .st_wdata     (st_wdata),
    .hold_time    (hold_time),
    .refresh_time (refresh_time),
    .st_value     (st_value),
    .busy         (busy),
    .sample_o     (sample_o),
    .hold_o       (hold_o),
    .refresh_o    (refresh_o)
);

// File: tb/sim_snh_timing_ctrl.sv
`timescale 1ns/1ps
module sim_snh_timing_ctrl;

    localparam int ST_W = 10;
    localparam int HT_W = 10;
    localparam int RT_W = 8;

    logic            clk = 1'b0;
    logic            ls_clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            chan_en = 1'b0;
    logic            mode_en = 1'b0;
    logic            st_wr = 1'b0;
    logic [ST_W-1:0] st_wdata = '0;
    logic [HT_W-1:0] hold_time = '0;
    logic [RT_W-1:0] refresh_time = '0;
    logic [ST_W-1:0] st_value;
    logic            busy;
    logic            sample_o;
    logic            hold_o;
    logic            refresh_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // run-length monitor on the slow clock, code = {sample, hold, refresh}
    bit         mon_en = 1'b0;
    logic [2:0] mon_last;
    int         mon_len;
    int         run_n;
    logic [2:0] run_code [256];
    int         run_len  [256];
    logic [2:0] exp_code [256];
    int         exp_len  [256];
    int         exp_n;

    always #2 clk = ~clk;
    initial begin
        #3;
        forever #25 ls_clk = ~ls_clk;
    end

    snh_timing_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ls_clk(ls_clk), .chan_en(chan_en),
        .mode_en(mode_en), .st_wr(st_wr), .st_wdata(st_wdata),
        .hold_time(hold_time), .refresh_time(refresh_time),
        .st_value(st_value), .busy(busy), .sample_o(sample_o),
        .hold_o(hold_o), .refresh_o(refresh_o)
    );

    always @(negedge ls_clk) begin
        if (mon_en) begin
            if ({sample_o, hold_o, refresh_o} == mon_last) begin
                mon_len++;
            end else begin
                if (run_n < 256) begin
                    run_code[run_n] = mon_last;
                    run_len[run_n]  = mon_len;
                    run_n++;
                end
                mon_last = {sample_o, hold_o, refresh_o};
                mon_len  = 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic bus_write(input int v);
        @(negedge clk);
        st_wr = 1'b1;
        st_wdata = ST_W'(v);
        @(negedge clk);
        st_wr = 1'b0;
    endtask

    task automatic wait_busy_clear(output int n);
        n = 0;
        while (busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // expected phase runs: cyclic sample/hold/refresh/hold, zeros skipped, equal neighbours merged
    task automatic build_exp(input int st, input int ht, input int rt);
        exp_n = 0;
        for (int p = 0; p < 200; p++) begin
            int d;
            logic [2:0] c;
            case (p % 4)
                0:       begin d = st; c = 3'b100; end
                2:       begin d = rt; c = 3'b001; end
                default: begin d = ht; c = 3'b010; end
            endcase
            if (d > 0) begin
                if (exp_n > 0 && exp_code[exp_n-1] == c) begin
                    exp_len[exp_n-1] += d;
                end else if (exp_n < 256) begin
                    exp_code[exp_n] = c;
                    exp_len[exp_n]  = d;
                    exp_n++;
                end
            end
        end
    endtask

    task automatic run_trial(input int st, input int ht, input int rt, input bit dbl);
        int n;
        logic [2:0] cur;
        @(negedge clk);
        chan_en = 1'b0;
        mode_en = 1'b0;
        hold_time = HT_W'(ht);
        refresh_time = RT_W'(rt);
        if (dbl) begin
            @(negedge clk);
            st_wr = 1'b1;
            st_wdata = ST_W'((st + 7) % 1024);
            @(negedge clk);
            st_wdata = ST_W'(st);
            @(negedge clk);
            st_wr = 1'b0;
            chk(st_value == ST_W'(st), "R5 second write taken while busy", int'(st_value), st);
            chk(busy == 1'b1, "R5 busy held for parked value", int'(busy), 1);
        end else begin
            bus_write(st);
            chk(st_value == ST_W'(st), "R2 write value", int'(st_value), st);
        end
        wait_busy_clear(n);
        chk(busy == 1'b0, "R3 busy clears", int'(busy), 0);
        mon_last = 3'b000;
        mon_len = 0;
        run_n = 0;
        mon_en = 1'b1;
        @(negedge clk);
        chan_en = 1'b1;
        mode_en = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R6 busy after mode rise", int'(busy), 1);
        repeat (80) @(posedge ls_clk);
        @(negedge clk);
        mon_en = 1'b0;
        cur = {sample_o, hold_o, refresh_o};
        build_exp(st, ht, rt);
        if (exp_n == 0) begin
            chk(run_n == 0 && cur == 3'b000, "R9 all zero stays quiet", int'(cur), 0);
        end else if (exp_n == 1) begin
            chk(run_n == 1 && cur == exp_code[0], "R9 single merged phase", int'(cur), int'(exp_code[0]));
        end else begin
            chk(run_n >= 3, "R7 phases switch", run_n, 3);
            for (int i = 1; i < run_n && i <= exp_n; i++) begin
                chk(run_code[i] == exp_code[i-1], "R7 phase order", int'(run_code[i]), int'(exp_code[i-1]));
                chk(run_len[i] == exp_len[i-1], (exp_code[i-1] == 3'b100 && dbl) ? "R5 R8 sample length" : "R8 phase length",
                    run_len[i], exp_len[i-1]);
            end
        end
        @(negedge clk);
        mode_en = 1'b0;
        chan_en = 1'b0;
        repeat (5) @(posedge ls_clk);
        @(negedge clk);
        chk({sample_o, hold_o, refresh_o} == 3'b000, "R10 outputs off after leaving mode",
            int'({sample_o, hold_o, refresh_o}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        int seed_val;
        int n;
        seed_val = $urandom(32'd4711);
        repeat (5) @(negedge clk);
        chk(busy == 1'b0 && st_value == '0, "R1 reset busy/value", int'(st_value), 0);
        chk({sample_o, hold_o, refresh_o} == 3'b000, "R1 reset phases", int'({sample_o, hold_o, refresh_o}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && st_value == '0, "R1 after reset release", int'(busy), 0);

        // R2 / R3: single transfer timing with channel off
        bus_write(5);
        chk(st_value == 10'd5, "R2 value after write", int'(st_value), 5);
        chk(busy == 1'b1, "R2 busy after write", int'(busy), 1);
        wait_busy_clear(n);
        chk(n >= 24 && n <= 48, "R3 busy window in bus cycles", n, 36);

        // R4: blocked write with channel on
        @(negedge clk);
        chan_en = 1'b1;
        bus_write(3);
        chk(busy == 1'b1, "R2 busy on accepted write", int'(busy), 1);
        bus_write(8);
        chk(st_value == 10'd3, "R4 write ignored while busy", int'(st_value), 3);
        wait_busy_clear(n);
        bus_write(8);
        chk(st_value == 10'd8, "R2 write taken once idle", int'(st_value), 8);
        wait_busy_clear(n);
        @(negedge clk);
        chan_en = 1'b0;

        // directed corner cases
        run_trial(3, 2, 4, 1'b0);
        run_trial(0, 3, 0, 1'b0);
        run_trial(0, 0, 0, 1'b0);
        run_trial(1, 1, 1, 1'b1);
        run_trial(4, 0, 2, 1'b1);
        run_trial(2, 0, 0, 1'b0);

        // constrained random durations
        for (int t = 0; t < 8; t++) begin
            int st;
            int ht;
            int rt;
            st = int'($urandom % 6);
            ht = int'($urandom % 6);
            rt = int'($urandom % 6);
            run_trial(st, ht, rt, 1'($urandom % 2));
        end

        done = 1'b1;
        finish_up();
    end

endmodule